// File: doc/BRIEF.md
# Accumulator-Register Instruction Execute Unit

This block is the execute stage of a small 8-bit accumulator machine. It holds a working register (W), a 32-entry byte register file and three status flags: carry, digit-carry and zero. Each cycle it receives one decoded operation with its operands. It performs that operation and commits the result on the clock edge that ends the cycle.

The operation set covers these cases:
- an add of W and a file register;
- an AND of W with a file register;
- an AND of W with an 8-bit literal;
- forcing a single bit of a file register high or low;
- a bit test that asks fetch to squash the next instruction when the tested bit is 0.

While that squash request is visible, the unit ignores the incoming instruction, so the test costs two cycles. Two read-only outputs let the surrounding pipeline observe state: the current W, and the content of the register that the address input selects.

Top module: `arx_exec_unit`

## Requirements
- R1: While rst_n is low, W, all 32 file registers, the three flags and skip_next are held at 0.
- R2: Operation code 1 (add) computes W + f[addr] modulo 256. If dst_f is 0 the result goes to W; if dst_f is 1 it goes to the addressed file register. The other location keeps its value.
- R3: The add sets the flags as follows: carry takes the carry out of bit 7, digit-carry takes the carry out of bit 3, and zero is 1 exactly when the 8-bit result is 0.
- R4: Operation code 2 (AND with register) computes W & f[addr] and sends it to W (dst_f=0) or to the file register (dst_f=1). It updates zero only; carry and digit-carry keep their values.
- R5: Operation code 3 (AND with literal) writes W & lit into W whatever dst_f is. It updates zero only and leaves the file registers alone.
- R6: Operation codes 4 (bit set) and 5 (bit clear) force bit bit_idx of f[addr] to 1 or 0 respectively. The other bits, W and all flags do not change.
- R7: Operation code 6 (bit test) raises skip_next in the following cycle exactly when bit bit_idx of f[addr] is 0. It changes no register and no flag.
- R8: skip_next is never high for two cycles in a row. While it is high, the instruction presented is discarded: no register or flag changes, even if that instruction is itself a bit test.
- R9: Operation codes 0 and 7 are no-ops and change no state.
- R10: Writes take effect at the end of their cycle and reads are combinational. An instruction in the next cycle therefore sees the value just written, and f_value always shows the addressed register's current content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_sel | input | 3 | Decoded operation code |
| f_addr | input | 5 | File register address |
| dst_f | input | 1 | Destination select: 0 sends the result to W, 1 to the file register |
| bit_idx | input | 3 | Bit position for the bit operations |
| lit | input | 8 | Literal operand |
| flag_c | output | 1 | Carry flag |
| flag_dc | output | 1 | Digit-carry flag |
| flag_z | output | 1 | Zero flag |
| skip_next | output | 1 | Tells fetch to turn the next instruction into a no-op |
| w_value | output | 8 | Current W |
| f_value | output | 8 | Current content of f[f_addr] |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- 0x0F + 0x01 must set digit-carry without carry. A wrong nibble tap would miss it.
- 0xFF + 0x01 must wrap to 0 with carry and zero set. A 9-bit result would leave zero clear.
- The literal AND must leave carry and digit-carry untouched. A design that refreshed all flags would wipe out a carry set earlier.
- A bit test issued during a skip must be discarded. If it were not, skip_next would stay high for two cycles and a second instruction would be dropped.
- Back-to-back dependent adds must see the previous result. A registered read port would return stale data.

Random streams of all eight codes, on a narrow address range, mix these hazards in further.

// File: rtl/arx_pkg.sv
package arx_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ADD_WF  = 3'd1,
    OP_AND_WF  = 3'd2,
    OP_AND_LIT = 3'd3,
    OP_BIT_SET = 3'd4,
    OP_BIT_CLR = 3'd5,
    OP_BIT_TST = 3'd6,
    OP_RSVD    = 3'd7
  } arx_op_e;

  typedef struct packed {
    logic c;
    logic dc;
    logic z;
  } arx_flags_t;
endpackage

// File: rtl/arx_regfile.sv
module arx_regfile #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data
);
  logic [DEPTH-1:0]            ent_en;
  logic [DEPTH-1:0][WIDTH-1:0] ent_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign ent_en[i] = wr_en && (addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ent_q[i] <= '0;
      else if (ent_en[i]) ent_q[i] <= wr_data;
    end
  end

  assign rd_data = ent_q[addr];

  // Each write must reach exactly one entry (R2, R4, R6).
  assert_one_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ent_en) && (wr_en -> ($countones(ent_en) == 1)));
  // The written value is visible at the read port in the next cycle (R10).
  assert_readback_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (($past(addr) != addr) || (rd_data == $past(wr_data))));
endmodule

// File: rtl/arx_alu.sv
module arx_alu
  import arx_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int BW  = $clog2(WIDTH),
  localparam int NIB = WIDTH / 2
) (
  input  arx_op_e          op,
  input  logic [WIDTH-1:0] w_in,
  input  logic [WIDTH-1:0] f_in,
  input  logic [WIDTH-1:0] lit,
  input  logic [BW-1:0]    bit_idx,
  output logic [WIDTH-1:0] result,
  output logic             carry,
  output logic             dcarry,
  output logic             zero,
  output logic             bit_val
);
  logic [WIDTH:0]   sum;
  logic [NIB:0]     low_sum;
  logic [WIDTH-1:0] mask;

  always_comb begin
    sum     = {1'b0, w_in} + {1'b0, f_in};
    low_sum = {1'b0, w_in[NIB-1:0]} + {1'b0, f_in[NIB-1:0]};
    mask    = WIDTH'(1) << bit_idx;
    bit_val = |(f_in & mask);
    carry   = sum[WIDTH];
    dcarry  = low_sum[NIB];
    unique case (op)
      OP_ADD_WF:  result = sum[WIDTH-1:0];
      OP_AND_WF:  result = w_in & f_in;
      OP_AND_LIT: result = w_in & lit;
      OP_BIT_SET: result = f_in | mask;
      OP_BIT_CLR: result = f_in & ~mask;
      default:    result = f_in;
    endcase
    zero = (result == '0);
  end
endmodule

// File: rtl/arx_exec_unit.sv
module arx_exec_unit
  import arx_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int BW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_sel,
  input  logic [AW-1:0]    f_addr,
  input  logic             dst_f,
  input  logic [BW-1:0]    bit_idx,
  input  logic [WIDTH-1:0] lit,
  output logic             flag_c,
  output logic             flag_dc,
  output logic             flag_z,
  output logic             skip_next,
  output logic [WIDTH-1:0] w_value,
  output logic [WIDTH-1:0] f_value
);
  arx_op_e          op;
  logic [WIDTH-1:0] w_q, w_d, alu_res, rf_rd;
  arx_flags_t       fl_q, fl_d;
  logic             skip_q, skip_d;
  logic             w_en, rf_en, fl_en, live;
  logic             alu_c, alu_dc, alu_z, alu_bit;

  assign op = arx_op_e'(op_sel);

  arx_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rf (
    .clk(clk), .rst_n(rst_n), .addr(f_addr), .wr_en(rf_en),
    .wr_data(alu_res), .rd_data(rf_rd)
  );

  arx_alu #(.WIDTH(WIDTH)) u_alu (
    .op(op), .w_in(w_q), .f_in(rf_rd), .lit(lit), .bit_idx(bit_idx),
    .result(alu_res), .carry(alu_c), .dcarry(alu_dc), .zero(alu_z),
    .bit_val(alu_bit)
  );

  // Next-state decode
  always_comb begin
    live   = !skip_q;
    w_en   = 1'b0;
    rf_en  = 1'b0;
    fl_en  = 1'b0;
    skip_d = 1'b0;
    w_d    = alu_res;
    fl_d   = fl_q;
    if (live) begin
      unique case (op)
        OP_ADD_WF: begin
          w_en  = !dst_f;
          rf_en = dst_f;
          fl_en = 1'b1;
          fl_d  = '{c: alu_c, dc: alu_dc, z: alu_z};
        end
        OP_AND_WF: begin
          w_en   = !dst_f;
          rf_en  = dst_f;
          fl_en  = 1'b1;
          fl_d.z = alu_z;
        end
        OP_AND_LIT: begin
          w_en   = 1'b1;
          fl_en  = 1'b1;
          fl_d.z = alu_z;
        end
        OP_BIT_SET, OP_BIT_CLR: rf_en = 1'b1;
        OP_BIT_TST: skip_d = !alu_bit;
        default: ;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q    <= '0;
      fl_q   <= '0;
      skip_q <= 1'b0;
    end else begin
      if (w_en)  w_q  <= w_d;
      if (fl_en) fl_q <= fl_d;
      skip_q <= skip_d;
    end
  end

  assign flag_c    = fl_q.c;
  assign flag_dc   = fl_q.dc;
  assign flag_z    = fl_q.z;
  assign skip_next = skip_q;
  assign w_value   = w_q;
  assign f_value   = rf_rd;

  assert_skip_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    skip_next |=> !skip_next);
  assert_squashed_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    skip_next |=> ($stable(w_value) && $stable({flag_c, flag_dc, flag_z})));
  assert_bitops_keep_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel inside {3'd4, 3'd5, 3'd6}) |=> $stable({flag_c, flag_dc, flag_z}));
  assert_test_keeps_w_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd6) |=> $stable(w_value));
  assert_nop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd0 || op_sel == 3'd7) |=>
      ($stable(w_value) && $stable({flag_c, flag_dc, flag_z}) && !skip_next));
  assert_lit_keeps_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd3) |=> ($stable(flag_c) && $stable(flag_dc)));
  assert_andf_keeps_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd2) |=> ($stable(flag_c) && $stable(flag_dc)));
endmodule

// File: tb/arx_exec_unit_test.sv
module arx_exec_unit_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] op_sel;
  logic [4:0] f_addr;
  logic       dst_f;
  logic [2:0] bit_idx;
  logic [7:0] lit;
  logic       flag_c, flag_dc, flag_z, skip_next;
  logic [7:0] w_value, f_value;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  logic [7:0] m_rf [32];
  logic [7:0] m_w;
  logic       m_c, m_dc, m_z, m_skip;

  always #2.5 clk = ~clk;

  arx_exec_unit uut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .f_addr(f_addr), .dst_f(dst_f),
    .bit_idx(bit_idx), .lit(lit), .flag_c(flag_c), .flag_dc(flag_dc),
    .flag_z(flag_z), .skip_next(skip_next), .w_value(w_value), .f_value(f_value)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] add9(input logic [7:0] a, input logic [7:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic half_carry(input logic [7:0] a, input logic [7:0] b);
    logic [4:0] s;
    s = {1'b0, a[3:0]} + {1'b0, b[3:0]};
    return s[4];
  endfunction

  // Advance the model by one instruction.
  task automatic model_step(input logic [2:0] op, input logic [4:0] a, input logic d,
                            input logic [2:0] b, input logic [7:0] k);
    logic [8:0] s;
    logic [7:0] r;
    logic       nskip;
    nskip = 1'b0;
    if (!m_skip) begin
      case (op)
        3'd1: begin
          s = add9(m_w, m_rf[a]);
          m_c  = s[8];
          m_dc = half_carry(m_w, m_rf[a]);
          m_z  = (s[7:0] == 8'h00);
          if (d) m_rf[a] = s[7:0]; else m_w = s[7:0];
        end
        3'd2: begin
          r = m_w & m_rf[a];
          m_z = (r == 8'h00);
          if (d) m_rf[a] = r; else m_w = r;
        end
        3'd3: begin
          m_w = m_w & k;
          m_z = (m_w == 8'h00);
        end
        3'd4: m_rf[a][b] = 1'b1;
        3'd5: m_rf[a][b] = 1'b0;
        3'd6: nskip = !m_rf[a][b];
        default: ;
      endcase
    end
    m_skip = nskip;
  endtask

  // Drive one instruction at the falling edge, check the combinational read, clock it,
  // then check all architectural outputs at the next falling edge.
  task automatic issue(input string req, input logic [2:0] op, input logic [4:0] a,
                       input logic d, input logic [2:0] b, input logic [7:0] k);
    op_sel = op; f_addr = a; dst_f = d; bit_idx = b; lit = k;
    #1;
    chk("R10", "f_value before edge", int'(f_value), int'(m_rf[a]));
    model_step(op, a, d, b, k);
    @(posedge clk);
    @(negedge clk);
    #1;
    chk(req, "W", int'(w_value), int'(m_w));
    chk(req, "f_value", int'(f_value), int'(m_rf[a]));
    chk(req, "flags", int'({flag_c, flag_dc, flag_z}), int'({m_c, m_dc, m_z}));
    chk(req, "skip_next", int'(skip_next), int'(m_skip));
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin : stim
    void'($urandom(32'h0000_5EED));
    rst_n = 1'b0; op_sel = 3'd0; f_addr = '0; dst_f = 1'b0; bit_idx = '0; lit = '0;
    for (int i = 0; i < 32; i++) m_rf[i] = 8'h00;
    m_w = 8'h00; m_c = 1'b0; m_dc = 1'b0; m_z = 1'b0; m_skip = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "W after reset", int'(w_value), 0);
    chk("R1", "flags after reset", int'({flag_c, flag_dc, flag_z}), 0);
    chk("R1", "skip after reset", int'(skip_next), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 32; i++) begin
      f_addr = 5'(i); #1;
      chk("R1", "file entry after reset", int'(f_value), 0);
    end

    // Load W = 0x0F: set bits 0..3 of f[1], then AND-with-register of W=0 gives 0.
    for (int b = 0; b < 4; b++) issue("R6", 3'd4, 5'd1, 1'b0, 3'(b), 8'h00);
    issue("R4", 3'd2, 5'd1, 1'b0, 3'd0, 8'h00);   // W = 0 & 0x0F = 0, Z=1
    issue("R2", 3'd1, 5'd1, 1'b0, 3'd0, 8'h00);   // W = 0x0F
    // R3: digit-carry without carry: f[2] = 0x01, W + f[2] = 0x10
    issue("R6", 3'd4, 5'd2, 1'b0, 3'd0, 8'h00);
    issue("R3", 3'd1, 5'd2, 1'b0, 3'd0, 8'h00);
    // R5: literal AND keeps carry/digit-carry, dst_f ignored
    issue("R5", 3'd3, 5'd2, 1'b1, 3'd0, 8'hF0);
    // R3: wrap 0xFF + 0x01 -> 0, C=1, DC=1, Z=1 into file (dst_f=1)
    for (int b = 0; b < 8; b++) issue("R6", 3'd4, 5'd3, 1'b0, 3'(b), 8'h00);
    issue("R2", 3'd2, 5'd3, 1'b0, 3'd0, 8'h00);   // W = 0x10 & 0xFF = 0x10
    issue("R5", 3'd3, 5'd0, 1'b0, 3'd0, 8'h00);   // W = 0
    issue("R3", 3'd1, 5'd2, 1'b0, 3'd0, 8'h00);   // W = 0x01
    issue("R3", 3'd1, 5'd3, 1'b1, 3'd0, 8'h00);   // f[3] = 0x00, C DC Z set
    issue("R5", 3'd3, 5'd0, 1'b0, 3'd0, 8'hFF);   // carry must survive
    // R7/R8: test a clear bit, squashed add and squashed test follow
    issue("R7", 3'd6, 5'd3, 1'b0, 3'd5, 8'h00);
    issue("R8", 3'd1, 5'd2, 1'b1, 3'd0, 8'h00);
    issue("R7", 3'd6, 5'd3, 1'b0, 3'd1, 8'h00);
    issue("R8", 3'd6, 5'd3, 1'b0, 3'd2, 8'h00);
    issue("R8", 3'd3, 5'd0, 1'b0, 3'd0, 8'h00);
    // R7: set bit tested -> no skip
    issue("R7", 3'd6, 5'd2, 1'b0, 3'd0, 8'h00);
    // R9: no-op codes 0 and 7
    issue("R9", 3'd0, 5'd2, 1'b1, 3'd0, 8'h00);
    issue("R9", 3'd7, 5'd2, 1'b1, 3'd0, 8'h00);
    // R10: dependent adds back to back into the same register
    issue("R10", 3'd1, 5'd2, 1'b1, 3'd0, 8'h00);
    issue("R10", 3'd1, 5'd2, 1'b1, 3'd0, 8'h00);
    issue("R6", 3'd5, 5'd2, 1'b0, 3'd0, 8'h00);

    // Random stream on a narrow address range
    for (int n = 0; n < 3000; n++) begin
      issue("R2", 3'($urandom_range(0, 7)), 5'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), 8'($urandom));
    end

    // Final sweep of the file against the model
    for (int i = 0; i < 32; i++) begin
      op_sel = 3'd0; f_addr = 5'(i); #1;
      chk("R10", "final file content", int'(f_value), int'(m_rf[i]));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule